// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of every access inside a short burst of up to four accesses. A load cycle captures a base address from the external address input; each following advance cycle steps a two-bit counter, and the two least significant address bits of the output are formed from the base and that counter. The upper address bits always come from the loaded base and never change during a burst.

A static ordering input chooses how the low bits move. In linear ordering they count upward from the base and wrap modulo four. In interleaved ordering they are the base bits XORed with the counter. A run enable freezes the whole block when low. A deselect indication sampled on a load cycle puts the block into an idle state. Advances that arrive while idle are ignored, so a new burst can only start with a load.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the valid flag is 0 and the address output is all zeros.
- R2: A cycle with run_en=1, advance=0 and desel=0 loads addr_in; from the next cycle addr_out equals that value and valid is 1.
- R3: With interleave=0, each accepted advance makes addr_out[1:0] equal (base[1:0] + count) mod 4, where count is the number of advances since the load.
- R4: With interleave=1, each accepted advance makes addr_out[1:0] equal base[1:0] XOR count.
- R5: The counter wraps after four advances, so the fourth advance returns addr_out to the loaded base in both orderings.
- R6: Bits above bit 1 of addr_out never change on an advance.
- R7: When run_en=0, addr_out and valid hold their values whatever the other inputs do.
- R8: A cycle with run_en=1, advance=0 and desel=1 clears valid and leaves addr_out unchanged.
- R9: An advance while valid is 0 leaves valid at 0 and addr_out unchanged.
- R10: The desel input is ignored on advance cycles: an advance with desel=1 while valid steps the address and keeps valid at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 = the cycle takes effect, 0 = hold all state |
| advance | input | 1 | 1 = step the burst counter, 0 = load or deselect |
| interleave | input | 1 | 0 = linear order, 1 = interleaved order; static during a burst |
| desel | input | 1 | On a non-advance cycle, 1 = go idle instead of loading |
| addr_in | input | AW | External base address |
| addr_out | output | AW | Address of the current access |
| valid | output | 1 | 1 while a loaded burst is active |

## Verification
The hardest situation to reach is an advance arriving while the block is idle, together with the wrap of the counter in each ordering. Reaching it requires first building a burst, deselecting it through a load-slot cycle, and then issuing advances. The stimulus table walks whole bursts of four steps in both orderings from bases with nonzero low bits. It then deselects and advances into the idle state, and it uses an all-ones base so that a wrap of the low bits cannot carry into the upper bits unnoticed.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          advance,
  input  logic          interleave,
  input  logic          desel,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          valid
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          act_q;
  logic [1:0]    low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (run_en) begin
      if (!advance) begin
        act_q <= !desel;
        if (!desel) begin
          base_q <= addr_in;
          cnt_q  <= '0;
        end
      end else if (act_q) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign low      = interleave ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
  assign addr_out = {base_q[AW-1:2], low};
  assign valid    = act_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          advance,
  input logic          interleave,
  input logic          desel,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic          valid
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !advance && !desel |=> valid && addr_out == $past(addr_in));
  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && advance && valid && !interleave |=>
      interleave || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && advance |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2]));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(addr_out[AW-1:2]) && $stable(valid));
  a_r8_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !advance && desel |=> !valid && $stable(addr_out[AW-1:2]));
  a_r9_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && advance && !valid |=> !valid && $stable(addr_out[AW-1:2]));
  a_r10_adv_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && advance && valid |=> valid);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .advance(advance),
  .interleave(interleave), .desel(desel), .addr_in(addr_in),
  .addr_out(addr_out), .valid(valid)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 16;
  localparam int NV = 16;
  // {run_en, advance, desel, interleave, addr_in, exp_valid, exp_addr, tag}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0,16'h1236,1'b1,16'h1236,4'd2},  // R2 load
    {1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,16'h1237,4'd3},  // R3
    {1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,16'h1234,4'd3},  // R3 low wrap
    {1'b1,1'b1,1'b1,1'b0,16'h0000,1'b1,16'h1235,4'd10}, // R10
    {1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,16'h1236,4'd5},  // R5
    {1'b0,1'b1,1'b0,1'b0,16'h9999,1'b1,16'h1236,4'd7},  // R7
    {1'b1,1'b0,1'b0,1'b1,16'hABC1,1'b1,16'hABC1,4'd2},  // R2
    {1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hABC0,4'd4},  // R4
    {1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hABC3,4'd4},  // R4
    {1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hABC2,4'd4},  // R4
    {1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hABC1,4'd5},  // R5
    {1'b1,1'b0,1'b1,1'b1,16'h5555,1'b0,16'hABC1,4'd8},  // R8
    {1'b1,1'b1,1'b0,1'b1,16'h0000,1'b0,16'hABC1,4'd9},  // R9
    {1'b1,1'b0,1'b0,1'b0,16'hFFFF,1'b1,16'hFFFF,4'd2},  // R2
    {1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,16'hFFFC,4'd6},  // R6
    {1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,16'hFFFC,4'd7}   // R7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_en = 1'b0, advance = 1'b0, interleave = 1'b0, desel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic valid;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .advance(advance),
    .interleave(interleave), .desel(desel), .addr_in(addr_in),
    .addr_out(addr_out), .valid(valid)
  );

  task automatic check(input int tag, input logic ev, input logic [AW-1:0] ea);
    checks++;
    if (valid !== ev || addr_out !== ea) begin
      failures++;
      $display("FAIL R%0d: valid=%b addr=%h expected valid=%b addr=%h",
               tag, valid, addr_out, ev, ea);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(1, 1'b0, '0);  // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      {run_en, advance, desel, interleave, addr_in} = VEC[i][40:21];
      @(negedge clk);
      check(int'(VEC[i][3:0]), VEC[i][20], VEC[i][19:4]);
    end
    // R9: idle advances over several cycles after deselect
    run_en = 1'b1; advance = 1'b0; desel = 1'b1;
    @(negedge clk);
    advance = 1'b1; desel = 1'b0;
    repeat (3) @(negedge clk);
    check(9, 1'b0, 16'hFFFC);
    // R1: reset mid-run clears state
    advance = 1'b0; addr_in = 16'h4321;
    @(negedge clk);
    check(2, 1'b1, 16'h4321);
    rst_n = 1'b0;
    #1;
    check(1, 1'b0, '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule